// File: doc/BRIEF.md
# DRAM Rank Boundary Decoder

This block turns a 33-bit physical address into the DRAM rank that holds it, for a memory controller with two channels of four ranks each. Software programs one 8-bit boundary per rank and one attribute byte per pair of ranks through a plain write port. Boundaries are cumulative upper limits counted in 32 MiB units. When two successive boundaries are equal, the rank between them is empty.

The block compares the two channels' tables on every cycle. When both tables hold the same values, the channels are treated as interleaved. In that case only the channel-0 table is used, with every boundary doubled, and address bit 6 selects the channel. When the tables differ, the eight ranks form one sequential address space: channel 0 ranks 0 to 3 come first, then channel 1 ranks 0 to 3.

Lookups use a valid/ready stream. One request is accepted when `req_valid` and `req_ready` are both high. Its result appears on the response side on the next cycle. A response is held, unchanged, for as long as `rsp_valid` is high and `rsp_ready` is low. During that time `req_ready` stays low, so no new request is taken. The request side is ready whenever the response register is empty or is being drained in the same cycle.

Top module: `rkd_decoder`

## Requirements
- R1: After reset, `rsp_valid` is 0 and `req_ready` is 1. All tables read as zero, so `interleaved` is 1, and every lookup misses with `rsp_attr_err` = 0.
- R2: A write is selected by `cfg_addr`. Addresses 0–3 hold the channel-0 boundaries of ranks 0–3, and 4–7 hold the channel-1 boundaries. Addresses 8–9 hold the channel-0 attribute bytes for rank pairs 0/1 and 2/3, and 10–11 hold the channel-1 attribute bytes. A write applies to lookups accepted from the next cycle on. A lookup accepted in the same cycle as a write still sees the old contents.
- R3: In sequential mode, slot k is numbered 0–3 for channel 0 ranks 0–3 and 4–7 for channel 1 ranks 0–3. The slot's limit is its boundary value. A lookup returns the lowest populated slot whose limit is greater than address bits 32:25. The result has `rsp_rank` = k and `rsp_chan` = k bit 2. Address bits 24:0 play no part.
- R4: A slot whose limit equals the previous slot's limit never matches. For slot 0, the previous limit is 0.
- R5: An address at or above every limit gives `rsp_miss` = 1 and `rsp_attr_err` = 0. In that case `rsp_rank`, `rsp_chan` and `rsp_page` are all 0.
- R6: In an attribute byte, bits 2:0 hold the even rank's code and bits 6:4 hold the odd rank's code. A matched rank whose code is 010 (4 KB), 011 (8 KB) or 100 (16 KB) gives `rsp_miss` = 0 and `rsp_page` = that code.
- R7: A matched rank with any other code (000, 001, 101, 110 or 111) gives `rsp_miss` = 1 and `rsp_attr_err` = 1. `rsp_rank` and `rsp_chan` name that rank, and `rsp_page` carries the raw code.
- R8: `interleaved` is 1 exactly when all four boundaries and all four attribute codes of channel 0 equal those of channel 1. A single differing field clears it.
- R9: In interleaved mode, the limit of rank r (0–3) is twice the channel-0 boundary. The code comes from channel 0. `rsp_rank` is r (bit 2 = 0) and `rsp_chan` is address bit 6.
- R10: A request accepted at a clock edge has its result on `rsp_valid` after that edge. `req_ready` is 0 whenever `rsp_valid` = 1 and `rsp_ready` = 0. While that holds, the response fields stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | 4 | Table entry select (map in R2) |
| cfg_wdata | input | 8 | Boundary value or attribute byte |
| interleaved | output | 1 | Channels populated identically |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted when high with valid |
| req_addr | input | 33 | Physical address to decode |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_miss | output | 1 | No usable rank for the address |
| rsp_attr_err | output | 1 | Matched rank has an unusable attribute code |
| rsp_rank | output | 3 | Rank slot index |
| rsp_chan | output | 1 | Channel of the result |
| rsp_page | output | 3 | Attribute code of the matched rank |

## Verification
A table write and a lookup can land on the same clock edge, and the change may also flip the interleave decision. The bench provokes this by driving `cfg_we` and `req_valid` in the same cycle. The write empties rank 0 of channel 0 and breaks channel symmetry. The bench checks that the response still reflects the old, interleaved table. It then checks that the next lookup of the same address resolves through the new sequential table to a different rank.

// File: rtl/rkd_pkg.sv
package rkd_pkg;

  localparam int ATTR_W   = 3;
  localparam int EVEN_LSB = 0;  // even rank code position inside an attribute byte
  localparam int ODD_LSB  = 4;  // odd rank code position inside an attribute byte

  typedef enum logic [ATTR_W-1:0] {
    PG_EMPTY = 3'b000,
    PG_4K    = 3'b010,
    PG_8K    = 3'b011,
    PG_16K   = 3'b100
  } page_code_e;

  function automatic logic code_usable(input logic [ATTR_W-1:0] code);
    return (code == PG_4K) || (code == PG_8K) || (code == PG_16K);
  endfunction

endpackage

// File: rtl/rkd_cfg_regs.sv
module rkd_cfg_regs
  import rkd_pkg::*;
#(
  parameter int RPC    = 4,
  parameter int BND_W  = 8,
  parameter int CFG_AW = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 cfg_we,
  input  logic [CFG_AW-1:0]                    cfg_addr,
  input  logic [BND_W-1:0]                     cfg_wdata,
  output logic [RPC-1:0][BND_W-1:0]            bnd_c0,
  output logic [RPC-1:0][BND_W-1:0]            bnd_c1,
  output logic [RPC-1:0][ATTR_W-1:0]           code_c0,
  output logic [RPC-1:0][ATTR_W-1:0]           code_c1
);

  localparam int HALF      = RPC / 2;
  localparam int ATTR_BASE = 2 * RPC;

  logic [1:0][RPC-1:0][BND_W-1:0]  bnd_q;
  logic [1:0][RPC-1:0][ATTR_W-1:0] code_q;

  // Boundaries occupy the first 2*RPC addresses, attribute bytes follow.
  // Addresses past the last attribute byte select nothing.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bnd_q  <= '0;
      code_q <= '0;
    end else if (cfg_we) begin
      for (int c = 0; c < 2; c++) begin
        for (int r = 0; r < RPC; r++) begin
          if (cfg_addr == CFG_AW'(c * RPC + r))
            bnd_q[c][r] <= cfg_wdata;
        end
        for (int j = 0; j < HALF; j++) begin
          if (cfg_addr == CFG_AW'(ATTR_BASE + c * HALF + j)) begin
            code_q[c][2*j]   <= cfg_wdata[EVEN_LSB +: ATTR_W];
            code_q[c][2*j+1] <= cfg_wdata[ODD_LSB +: ATTR_W];
          end
        end
      end
    end
  end

  assign bnd_c0  = bnd_q[0];
  assign bnd_c1  = bnd_q[1];
  assign code_c0 = code_q[0];
  assign code_c1 = code_q[1];

endmodule

// File: rtl/rkd_sym_detect.sv
module rkd_sym_detect
  import rkd_pkg::*;
#(
  parameter int RPC   = 4,
  parameter int BND_W = 8
) (
  input  logic [RPC-1:0][BND_W-1:0]  bnd_c0,
  input  logic [RPC-1:0][BND_W-1:0]  bnd_c1,
  input  logic [RPC-1:0][ATTR_W-1:0] code_c0,
  input  logic [RPC-1:0][ATTR_W-1:0] code_c1,
  output logic                       sym
);

  logic [RPC-1:0] rank_same;

  // Per-rank equality, then an AND across ranks.
  for (genvar r = 0; r < RPC; r++) begin : g_rank
    assign rank_same[r] = (bnd_c0[r] == bnd_c1[r]) && (code_c0[r] == code_c1[r]);
  end

  assign sym = &rank_same;

endmodule

// File: rtl/rkd_rank_match.sv
module rkd_rank_match
  import rkd_pkg::*;
#(
  parameter int RPC    = 4,
  parameter int BND_W  = 8,
  parameter int UNIT_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic [UNIT_W-1:0]          unit,
  input  logic                       ilv,
  input  logic [RPC-1:0][BND_W-1:0]  bnd_c0,
  input  logic [RPC-1:0][BND_W-1:0]  bnd_c1,
  input  logic [RPC-1:0][ATTR_W-1:0] code_c0,
  input  logic [RPC-1:0][ATTR_W-1:0] code_c1,
  output logic                       hit,
  output logic [IDX_W-1:0]           hit_idx,
  output logic [ATTR_W-1:0]          hit_code
);

  localparam int NR    = 2 * RPC;
  localparam int CMP_W = BND_W + 1;

  logic [CMP_W-1:0]  unit_x;
  logic [CMP_W-1:0]  lim  [NR];
  logic [ATTR_W-1:0] code [NR];
  logic [NR-1:0]     cand;

  assign unit_x = CMP_W'(unit);

  for (genvar k = 0; k < NR; k++) begin : g_slot
    logic [CMP_W-1:0] seq_lim;
    logic [CMP_W-1:0] ilv_lim;
    logic [CMP_W-1:0] prev_lim;

    if (k < RPC) begin : g_c0
      assign seq_lim = {1'b0, bnd_c0[k]};
      assign ilv_lim = {bnd_c0[k], 1'b0};
      assign code[k] = code_c0[k];
    end else begin : g_c1
      assign seq_lim = {1'b0, bnd_c1[k-RPC]};
      assign ilv_lim = '0;            // upper slots unused when interleaved
      assign code[k] = code_c1[k-RPC];
    end

    if (k == 0) begin : g_first
      assign prev_lim = '0;
    end else begin : g_next
      assign prev_lim = lim[k-1];
    end

    assign lim[k]  = ilv ? ilv_lim : seq_lim;
    // Populated (limit moved) and still above the address.
    assign cand[k] = (lim[k] > unit_x) && (lim[k] != prev_lim);
  end

  // Lowest candidate wins.
  always_comb begin
    hit_idx = '0;
    for (int k = NR - 1; k >= 0; k--) begin
      if (cand[k]) hit_idx = IDX_W'(k);
    end
  end

  assign hit      = |cand;
  assign hit_code = code[hit_idx];

endmodule

// File: rtl/rkd_decoder.sv
module rkd_decoder
  import rkd_pkg::*;
#(
  parameter int ADDR_W      = 33,
  parameter int GRAIN_SHIFT = 25,
  parameter int RANKS_PER_CH = 4,
  parameter int BND_W       = 8,
  parameter int ILV_BIT     = 6,
  localparam int NR         = 2 * RANKS_PER_CH,
  localparam int RANK_W     = $clog2(NR),
  localparam int NREG       = 3 * RANKS_PER_CH,
  localparam int CFG_AW     = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [BND_W-1:0]  cfg_wdata,
  output logic              interleaved,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_miss,
  output logic              rsp_attr_err,
  output logic [RANK_W-1:0] rsp_rank,
  output logic              rsp_chan,
  output logic [ATTR_W-1:0] rsp_page
);

  localparam int UNIT_W = ADDR_W - GRAIN_SHIFT;

  logic [RANKS_PER_CH-1:0][BND_W-1:0]  bnd_c0, bnd_c1;
  logic [RANKS_PER_CH-1:0][ATTR_W-1:0] code_c0, code_c1;
  logic                                hit;
  logic [RANK_W-1:0]                   hit_idx;
  logic [ATTR_W-1:0]                   hit_code;
  logic                                accept;

  logic              nx_miss, nx_err, nx_chan;
  logic [RANK_W-1:0] nx_rank;
  logic [ATTR_W-1:0] nx_page;

  logic unused_low_addr;
  assign unused_low_addr = ^req_addr[GRAIN_SHIFT-1:0];

  rkd_cfg_regs #(
    .RPC(RANKS_PER_CH), .BND_W(BND_W), .CFG_AW(CFG_AW)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .bnd_c0(bnd_c0), .bnd_c1(bnd_c1),
    .code_c0(code_c0), .code_c1(code_c1)
  );

  rkd_sym_detect #(
    .RPC(RANKS_PER_CH), .BND_W(BND_W)
  ) u_sym (
    .bnd_c0(bnd_c0), .bnd_c1(bnd_c1),
    .code_c0(code_c0), .code_c1(code_c1),
    .sym(interleaved)
  );

  rkd_rank_match #(
    .RPC(RANKS_PER_CH), .BND_W(BND_W), .UNIT_W(UNIT_W), .IDX_W(RANK_W)
  ) u_match (
    .unit(req_addr[ADDR_W-1:GRAIN_SHIFT]),
    .ilv(interleaved),
    .bnd_c0(bnd_c0), .bnd_c1(bnd_c1),
    .code_c0(code_c0), .code_c1(code_c1),
    .hit(hit), .hit_idx(hit_idx), .hit_code(hit_code)
  );

  // Result formation: clean miss, attribute fault, or good hit.
  always_comb begin
    nx_miss = 1'b1;
    nx_err  = 1'b0;
    nx_rank = '0;
    nx_chan = 1'b0;
    nx_page = '0;
    if (hit) begin
      nx_rank = hit_idx;
      nx_chan = interleaved ? req_addr[ILV_BIT] : hit_idx[RANK_W-1];
      nx_page = hit_code;
      nx_miss = !code_usable(hit_code);
      nx_err  = !code_usable(hit_code);
    end
  end

  // Single output register with pass-through back-pressure.
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_miss     <= 1'b0;
      rsp_attr_err <= 1'b0;
      rsp_rank     <= '0;
      rsp_chan     <= 1'b0;
      rsp_page     <= '0;
    end else if (accept) begin
      rsp_valid    <= 1'b1;
      rsp_miss     <= nx_miss;
      rsp_attr_err <= nx_err;
      rsp_rank     <= nx_rank;
      rsp_chan     <= nx_chan;
      rsp_page     <= nx_page;
    end else if (rsp_ready) begin
      rsp_valid    <= 1'b0;
    end
  end

endmodule

// File: rtl/rkd_decoder_chk.sv
module rkd_decoder_chk #(
  parameter int RANK_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              interleaved,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_miss,
  input logic              rsp_attr_err,
  input logic [RANK_W-1:0] rsp_rank,
  input logic              rsp_chan,
  input logic [2:0]        rsp_page
);

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable({rsp_miss, rsp_attr_err, rsp_rank, rsp_chan, rsp_page})); // R10

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready); // R10

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid); // R10

  AST_ERR_IS_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_attr_err |-> rsp_miss); // R7

  AST_HIT_PAGE_OK: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_miss |-> (rsp_page == 3'b010 || rsp_page == 3'b011 || rsp_page == 3'b100)); // R6

  AST_MISS_ZEROED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_miss && !rsp_attr_err |-> rsp_rank == '0 && !rsp_chan && rsp_page == 3'b000); // R5

  AST_ILV_LOW_RANKS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && interleaved |=> !rsp_rank[RANK_W-1]); // R9

  AST_SEQ_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !interleaved |=> rsp_chan == rsp_rank[RANK_W-1]); // R3

endmodule

bind rkd_decoder rkd_decoder_chk #(.RANK_W(RANK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .interleaved(interleaved),
  .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_miss(rsp_miss), .rsp_attr_err(rsp_attr_err),
  .rsp_rank(rsp_rank), .rsp_chan(rsp_chan), .rsp_page(rsp_page)
);

// File: tb/rkd_decoder_test.sv
module rkd_decoder_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        interleaved;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [32:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_miss, rsp_attr_err, rsp_chan;
  logic [2:0]  rsp_rank, rsp_page;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz
  always @(posedge clk) cycles++;

  rkd_decoder uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .interleaved(interleaved),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_miss(rsp_miss), .rsp_attr_err(rsp_attr_err),
    .rsp_rank(rsp_rank), .rsp_chan(rsp_chan), .rsp_page(rsp_page)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [32:0] at_unit(input int unsigned u, input logic [24:0] low);
    return (33'(u) << 25) | 33'(low);
  endfunction

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic expect_rsp(input string tag, input logic miss, input logic err,
                            input logic [2:0] rank, input logic chan, input logic [2:0] page);
    check({tag, " valid"}, 64'(rsp_valid), 64'd1);
    check({tag, " miss"},  64'(rsp_miss), 64'(miss));
    check({tag, " err"},   64'(rsp_attr_err), 64'(err));
    check({tag, " rank"},  64'(rsp_rank), 64'(rank));
    check({tag, " chan"},  64'(rsp_chan), 64'(chan));
    check({tag, " page"},  64'(rsp_page), 64'(page));
  endtask

  task automatic look(input string tag, input logic [32:0] a, input logic miss, input logic err,
                      input logic [2:0] rank, input logic chan, input logic [2:0] page);
    @(negedge clk);
    rsp_ready = 1'b1; req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    expect_rsp(tag, miss, err, rank, chan, page);
  endtask

  task automatic t_reset();
    check("R1 rsp_valid idle", 64'(rsp_valid), 64'd0);
    check("R1 req_ready idle", 64'(req_ready), 64'd1);
    check("R1 interleaved on empty tables", 64'(interleaved), 64'd1);
    look("R1 lookup after reset", at_unit(0, 25'h0), 1'b1, 1'b0, 3'd0, 1'b0, 3'd0);
  endtask

  task automatic t_sequential();
    wr(4'd0, 8'd2);  wr(4'd1, 8'd2);  wr(4'd2, 8'd6);  wr(4'd3, 8'd8);
    wr(4'd4, 8'd10); wr(4'd5, 8'd12); wr(4'd6, 8'd12); wr(4'd7, 8'd16);
    wr(4'd8, 8'h02); wr(4'd9, 8'h43); wr(4'd10, 8'h32); wr(4'd11, 8'h50);
    check("R8 differing tables", 64'(interleaved), 64'd0);
    look("R3 slot0 unit0",       at_unit(0, 25'h1234), 1'b0, 1'b0, 3'd0, 1'b0, 3'b010);
    look("R3 slot0 unit1",       at_unit(1, 25'h1FFFFFF), 1'b0, 1'b0, 3'd0, 1'b0, 3'b010);
    look("R4 skip empty slot1",  at_unit(2, 25'h0), 1'b0, 1'b0, 3'd2, 1'b0, 3'b011);
    look("R6 odd field slot3",   at_unit(7, 25'h40), 1'b0, 1'b0, 3'd3, 1'b0, 3'b100);
    look("R3 ch1 slot4",         at_unit(8, 25'h0), 1'b0, 1'b0, 3'd4, 1'b1, 3'b010);
    look("R6 ch1 slot5",         at_unit(11, 25'h0), 1'b0, 1'b0, 3'd5, 1'b1, 3'b011);
    look("R7 reserved code",     at_unit(12, 25'h0), 1'b1, 1'b1, 3'd7, 1'b1, 3'b101);
    look("R5 at top limit",      at_unit(16, 25'h0), 1'b1, 1'b0, 3'd0, 1'b0, 3'd0);
    look("R5 highest address",   at_unit(255, 25'h1FFFFFF), 1'b1, 1'b0, 3'd0, 1'b0, 3'd0);
  endtask

  task automatic t_interleaved();
    wr(4'd0, 8'd1); wr(4'd1, 8'd3); wr(4'd2, 8'd3); wr(4'd3, 8'd4);
    wr(4'd4, 8'd1); wr(4'd5, 8'd3); wr(4'd6, 8'd3); wr(4'd7, 8'd4);
    wr(4'd8, 8'h32); wr(4'd9, 8'h40); wr(4'd10, 8'h32); wr(4'd11, 8'h40);
    check("R8 identical tables", 64'(interleaved), 64'd1);
    look("R9 rank0 chan0",        at_unit(0, 25'h0), 1'b0, 1'b0, 3'd0, 1'b0, 3'b010);
    look("R9 doubled rank0 chan1", at_unit(1, 25'h40), 1'b0, 1'b0, 3'd0, 1'b1, 3'b010);
    look("R9 doubled rank1",      at_unit(3, 25'h0), 1'b0, 1'b0, 3'd1, 1'b0, 3'b011);
    look("R9 empty rank2 skipped", at_unit(6, 25'h40), 1'b0, 1'b0, 3'd3, 1'b1, 3'b100);
    look("R9 past doubled top",   at_unit(8, 25'h0), 1'b1, 1'b0, 3'd0, 1'b0, 3'd0);
    wr(4'd11, 8'h30);
    check("R8 one attribute differs", 64'(interleaved), 64'd0);
    wr(4'd11, 8'h40);
    check("R8 attribute restored", 64'(interleaved), 64'd1);
    wr(4'd7, 8'd5);
    check("R8 one boundary differs", 64'(interleaved), 64'd0);
    wr(4'd7, 8'd4);
    check("R8 boundary restored", 64'(interleaved), 64'd1);
  endtask

  task automatic t_write_and_lookup();
    @(negedge clk);
    rsp_ready = 1'b1; req_valid = 1'b1; req_addr = at_unit(0, 25'h0);
    cfg_we = 1'b1; cfg_addr = 4'd0; cfg_wdata = 8'd0;
    @(negedge clk);
    req_valid = 1'b0; cfg_we = 1'b0;
    expect_rsp("R2 same-cycle uses old table", 1'b0, 1'b0, 3'd0, 1'b0, 3'b010);
    check("R2 write landed", 64'(interleaved), 64'd0);
    look("R2 next lookup sees new table", at_unit(0, 25'h0), 1'b0, 1'b0, 3'd1, 1'b0, 3'b011);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_addr = at_unit(0, 25'h0);
    @(negedge clk);
    req_addr = at_unit(3, 25'h0);
    check("R10 ready low while stalled", 64'(req_ready), 64'd0);
    expect_rsp("R10 first result", 1'b0, 1'b0, 3'd1, 1'b0, 3'b011);
    @(negedge clk);
    check("R10 still stalled", 64'(req_ready), 64'd0);
    expect_rsp("R10 result held", 1'b0, 1'b0, 3'd1, 1'b0, 3'b011);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    expect_rsp("R10 second result after drain", 1'b0, 1'b0, 3'd3, 1'b0, 3'b100);
    @(negedge clk);
    check("R10 drained", 64'(rsp_valid), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sequential();
    t_interleaved();
    t_write_and_lookup();
    t_backpressure();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    wait (cycles >= 20000);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  end

endmodule